// File: doc/BRIEF.md
# Fractional-Modulus Phase Accumulator NCO

This block is the phase engine of a numerically controlled oscillator. An integer frequency word is added to a 32-bit phase accumulator on every clock. A fractional path extends the frequency resolution. A numerator is added into a residue register each cycle, and whenever the residue reaches the programmed modulus the modulus is removed and one extra count goes into the integer add. With the modulus at 2^31 the integer word and the numerator together act as one 63-bit tuning word.

The top 16 bits of the accumulator are added to a 16-bit phase offset and registered as the output phase. A 12-bit amplitude code travels with the phase at the same latency. Both outputs feed a downstream sine lookup.

All settings are staged on the configuration inputs and take effect only on an update strobe. The mode input sampled with the strobe selects what happens to the accumulators. In continuous mode they carry on unchanged. In auto-clear mode they are zeroed, so the phase right after the change equals the new offset.

Top module: `frac_nco`

## Requirements
- R1: After reset, `phase_out` and `amp_out` are zero, and with an all-zero configuration they stay zero.
- R2: `phase_out` equals (accumulator bits 31..16 + active offset) mod 2^16, one clock after the accumulator value. An offset sum above 0xFFFF wraps.
- R3: An update with `upd_autoclr`=1 zeroes the integer accumulator and the fractional residue on the update edge. The `phase_out` value present after the second edge following the update edge equals the new offset.
- R4: An update with `upd_autoclr`=0 leaves the accumulators running. The add on the update edge still uses the previously active frequency word, and the new word applies from the next edge.
- R5: Each clock the numerator A (`frac_num_in`, with A < B) is added to the residue. When the sum is at least the modulus B (`frac_mod_in`), B is subtracted and a carry of one enters the integer accumulator add. After clear, the accumulator after j clocks is j·F + floor(j·A/B) mod 2^32.
- R6: With B = 2^31, the 63-bit word X maps to F = X[62:31] and A = X[30:0]. The accumulator then steps as a 63-bit phase, and the output is X-phase bits 62..47 plus the offset.
- R7: With A = 0 the accumulator advances by exactly F every clock.
- R8: With B = 0 the fractional path is disabled and no carry is ever injected, whatever A holds.
- R9: Changes on any configuration input, including `upd_autoclr`, have no effect while `upd_stb` is low.
- R10: `amp_out` shows the amplitude code loaded by an update two edges after the update edge, the same latency as the phase. Full scale 0xFFF passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Update strobe, loads the staged configuration |
| upd_autoclr | input | 1 | Sampled with the strobe: 1 zeroes the accumulators, 0 keeps them |
| ftw_in | input | 32 | Staged integer frequency word F |
| frac_num_in | input | 31 | Staged fractional numerator A |
| frac_mod_in | input | 32 | Staged fractional modulus B (0 disables) |
| phase_ofs_in | input | 16 | Staged phase offset |
| amp_in | input | 12 | Staged amplitude code |
| phase_out | output | 16 | Registered output phase |
| amp_out | output | 12 | Registered amplitude code |

## Verification
The bench picks integer words whose multiples land exactly on a 2^16 boundary, such as 0x5555 with B=3 and 0x3333 with B=5. At those points a missing or misplaced fractional carry changes the visible top phase bits, so a design that drops carries or carries at the wrong residue would read one step low. A continuous update placed mid-run exposes a design that applies the new word on the update edge itself or clears the accumulator anyway, since every later phase would shift. A 63-bit word is compared against a bench-side 63-bit accumulator, which catches a wrong split of the word between F and A. Staged inputs changed without a strobe, a B=0 run and a latency probe of the amplitude show designs that load early, carry with a zero modulus, or misalign amplitude with phase.

// File: rtl/frac_nco_pkg.sv
package frac_nco_pkg;
  localparam int NCO_ACC_W  = 32;
  localparam int NCO_FRAC_W = 31;
  localparam int NCO_PH_W   = 16;
  localparam int NCO_AMP_W  = 12;

  typedef enum logic {
    UPD_KEEP  = 1'b0,
    UPD_CLEAR = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/nco_cfg_bank.sv
module nco_cfg_bank #(
  parameter int ACC_W  = frac_nco_pkg::NCO_ACC_W,
  parameter int FRAC_W = frac_nco_pkg::NCO_FRAC_W,
  parameter int PH_W   = frac_nco_pkg::NCO_PH_W,
  parameter int AMP_W  = frac_nco_pkg::NCO_AMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic              upd_autoclr,
  input  logic [ACC_W-1:0]  ftw_in,
  input  logic [FRAC_W-1:0] num_in,
  input  logic [FRAC_W:0]   mod_in,
  input  logic [PH_W-1:0]   ofs_in,
  input  logic [AMP_W-1:0]  amp_in,
  output logic [ACC_W-1:0]  ftw_act,
  output logic [FRAC_W-1:0] num_act,
  output logic [FRAC_W:0]   mod_act,
  output logic [PH_W-1:0]   ofs_act,
  output logic [AMP_W-1:0]  amp_act,
  output logic              upd_clear
);
  import frac_nco_pkg::*;

  localparam logic [FRAC_W:0] MOD_RST = {1'b1, {FRAC_W{1'b0}}};

  upd_mode_e mode_now;
  assign mode_now  = upd_mode_e'(upd_autoclr);
  assign upd_clear = upd_stb && (mode_now == UPD_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_act <= '0;
      num_act <= '0;
      mod_act <= MOD_RST;
      ofs_act <= '0;
      amp_act <= '0;
    end else if (upd_stb) begin
      ftw_act <= ftw_in;
      num_act <= num_in;
      mod_act <= mod_in;
      ofs_act <= ofs_in;
      amp_act <= amp_in;
    end
  end

  // R9
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> ($stable(ftw_act) && $stable(num_act) && $stable(mod_act)
                  && $stable(ofs_act) && $stable(amp_act)));
endmodule

// File: rtl/nco_frac_acc.sv
module nco_frac_acc #(
  parameter int FRAC_W = frac_nco_pkg::NCO_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W:0]   modulus,
  output logic              carry
);
  localparam int RES_W = FRAC_W + 1;

  // Returns {carry, next residue}
  function automatic logic [RES_W:0] frac_next(
    input logic [RES_W-1:0]  res,
    input logic [FRAC_W-1:0] a,
    input logic [RES_W-1:0]  b
  );
    logic [RES_W:0] sum;
    logic [RES_W:0] diff;
    sum  = {1'b0, res} + {2'b00, a};
    diff = sum - {1'b0, b};
    if ((b != '0) && (sum >= {1'b0, b}))
      return {1'b1, diff[RES_W-1:0]};
    else
      return {1'b0, sum[RES_W-1:0]};
  endfunction

  logic [RES_W-1:0] res_q;
  logic [RES_W:0]   step;

  assign step  = frac_next(res_q, num, modulus);
  assign carry = step[RES_W] && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) res_q <= '0;
    else               res_q <= step[RES_W-1:0];
  end

  // R5
  frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && modulus != '0 && res_q < modulus && {1'b0, num} < modulus)
      |=> res_q < $past(modulus));
  // R3
  frac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> res_q == '0);
  // R8
  no_carry_b0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modulus == '0) |-> !carry);
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = frac_nco_pkg::NCO_ACC_W,
  parameter int PH_W  = frac_nco_pkg::NCO_PH_W,
  parameter int AMP_W = frac_nco_pkg::NCO_AMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] ftw,
  input  logic             carry,
  input  logic [PH_W-1:0]  ofs,
  input  logic [AMP_W-1:0] amp,
  output logic [PH_W-1:0]  phase_out,
  output logic [AMP_W-1:0] amp_out
);
  localparam int TOP_LO = ACC_W - PH_W;

  function automatic logic [PH_W-1:0] phase_of(
    input logic [ACC_W-1:0] acc,
    input logic [PH_W-1:0]  o
  );
    return acc[ACC_W-1:TOP_LO] + o;
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_q;
  logic [AMP_W-1:0] amp_q;
  logic [ACC_W-1:0] carry_w;

  assign carry_w = {{(ACC_W-1){1'b0}}, carry};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= '0;
      amp_q   <= '0;
    end else begin
      acc_q   <= clr ? '0 : (acc_q + ftw + carry_w);
      phase_q <= phase_of(acc_q, ofs);
      amp_q   <= amp;
    end
  end

  assign phase_out = phase_q;
  assign amp_out   = amp_q;

  // R3
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);
  // R7
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !carry) |=> (acc_q - $past(acc_q)) == $past(ftw));
endmodule

// File: rtl/frac_nco.sv
module frac_nco #(
  parameter int ACC_W  = frac_nco_pkg::NCO_ACC_W,
  parameter int FRAC_W = frac_nco_pkg::NCO_FRAC_W,
  parameter int PH_W   = frac_nco_pkg::NCO_PH_W,
  parameter int AMP_W  = frac_nco_pkg::NCO_AMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic              upd_autoclr,
  input  logic [ACC_W-1:0]  ftw_in,
  input  logic [FRAC_W-1:0] frac_num_in,
  input  logic [FRAC_W:0]   frac_mod_in,
  input  logic [PH_W-1:0]   phase_ofs_in,
  input  logic [AMP_W-1:0]  amp_in,
  output logic [PH_W-1:0]   phase_out,
  output logic [AMP_W-1:0]  amp_out
);
  logic [ACC_W-1:0]  ftw_act;
  logic [FRAC_W-1:0] num_act;
  logic [FRAC_W:0]   mod_act;
  logic [PH_W-1:0]   ofs_act;
  logic [AMP_W-1:0]  amp_act;
  logic              upd_clear;
  logic              frac_carry;

  nco_cfg_bank #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .upd_autoclr(upd_autoclr),
    .ftw_in(ftw_in), .num_in(frac_num_in), .mod_in(frac_mod_in),
    .ofs_in(phase_ofs_in), .amp_in(amp_in),
    .ftw_act(ftw_act), .num_act(num_act), .mod_act(mod_act),
    .ofs_act(ofs_act), .amp_act(amp_act), .upd_clear(upd_clear)
  );

  nco_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .clr(upd_clear),
    .num(num_act), .modulus(mod_act), .carry(frac_carry)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(upd_clear), .ftw(ftw_act),
    .carry(frac_carry), .ofs(ofs_act), .amp(amp_act),
    .phase_out(phase_out), .amp_out(amp_out)
  );

  // R3
  ofs_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && upd_autoclr) |-> ##2 (phase_out == $past(phase_ofs_in, 2)));
  // R10
  amp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> ##2 (amp_out == $past(amp_in, 2)));
endmodule

// File: tb/frac_nco_test.sv
module frac_nco_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_stb = 1'b0;
  logic        upd_autoclr = 1'b0;
  logic [31:0] ftw_in = '0;
  logic [30:0] frac_num_in = '0;
  logic [31:0] frac_mod_in = 32'h8000_0000;
  logic [15:0] phase_ofs_in = '0;
  logic [11:0] amp_in = '0;
  logic [15:0] phase_out;
  logic [11:0] amp_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  frac_nco uut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .upd_autoclr(upd_autoclr),
    .ftw_in(ftw_in), .frac_num_in(frac_num_in), .frac_mod_in(frac_mod_in),
    .phase_ofs_in(phase_ofs_in), .amp_in(amp_in),
    .phase_out(phase_out), .amp_out(amp_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the negedge after the update edge.
  task automatic do_update(input logic [31:0] f, input logic [30:0] a, input logic [31:0] b,
                           input logic [15:0] o, input logic [11:0] amp, input logic clr);
    ftw_in = f; frac_num_in = a; frac_mod_in = b;
    phase_ofs_in = o; amp_in = amp; upd_autoclr = clr; upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  // Expected phase j clocks after a clear, generic fractional formula.
  function automatic logic [15:0] exp_phase(input int j, input logic [31:0] f,
      input logic [30:0] a, input logic [31:0] b, input logic [15:0] o);
    logic [63:0] t;
    t = 64'(j) * 64'(f);
    if (b != 0) t = t + (64'(j) * 64'(a)) / 64'(b);
    return t[31:16] + o;
  endfunction

  task automatic test_reset();
    check("R1 reset phase", 32'(phase_out), 32'h0);
    check("R1 reset amp", 32'(amp_out), 32'h0);
    repeat (3) @(negedge clk);
    check("R1 idle phase", 32'(phase_out), 32'h0);
  endtask

  task automatic test_clear();
    do_update(32'h0100_0000, 31'h0, 32'h8000_0000, 16'hFF00, 12'h800, 1'b1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R3 R2 clear+offset wrap", 32'(phase_out),
            32'(16'((k - 1) * 16'h0100 + 16'hFF00)));
    end
  endtask

  task automatic test_ext();
    logic [62:0] x;
    logic [62:0] m;
    x = 63'h2AF3_1C5D_9E07_B4A1;
    m = '0;
    do_update(x[62:31], x[30:0], 32'h8000_0000, 16'h0000, 12'hFFF, 1'b1);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R6 63-bit word", 32'(phase_out), 32'(m[62:47]));
      m = m + x;
    end
  endtask

  task automatic test_azero();
    logic [31:0] f;
    logic [31:0] t;
    f = 32'h9E37_79B9;
    do_update(f, 31'h0, 32'h8000_0000, 16'h0011, 12'h0FF, 1'b1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      t = 32'(k - 1) * f;
      check("R7 A zero", 32'(phase_out), 32'(t[31:16] + 16'h0011));
    end
  endtask

  task automatic test_frac(input logic [31:0] f, input logic [30:0] a, input logic [31:0] b,
                           input string req);
    do_update(f, a, b, 16'h0000, 12'h001, 1'b1);
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      check(req, 32'(phase_out), 32'(exp_phase(k - 1, f, a, b, 16'h0)));
    end
  endtask

  task automatic test_cont();
    logic [31:0] f1;
    logic [31:0] f2;
    logic [31:0] t;
    f1 = 32'h0123_4567;
    f2 = 32'h0765_4321;
    do_update(f1, 31'h0, 32'h8000_0000, 16'h0000, 12'h010, 1'b1);
    repeat (3) @(negedge clk);
    do_update(f2, 31'h0, 32'h8000_0000, 16'h0100, 12'h010, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      t = 32'd4 * f1 + 32'(k - 1) * f2;
      check("R4 continuous update", 32'(phase_out), 32'(t[31:16] + 16'h0100));
    end
  endtask

  task automatic test_hold();
    do_update(32'h0200_0000, 31'h0, 32'h8000_0000, 16'h0040, 12'h123, 1'b1);
    ftw_in = 32'hDEAD_BEEF; frac_num_in = 31'h1; frac_mod_in = 32'h3;
    phase_ofs_in = 16'h7777; amp_in = 12'hABC; upd_autoclr = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R9 no strobe phase", 32'(phase_out), 32'(16'((k - 1) * 16'h0200 + 16'h0040)));
      check("R9 no strobe amp", 32'(amp_out), 32'h123);
    end
  endtask

  task automatic test_amp();
    do_update(32'h0, 31'h0, 32'h8000_0000, 16'h0, 12'hFFF, 1'b0);
    check("R10 amp latency old", 32'(amp_out), 32'h123);
    @(negedge clk);
    check("R10 amp full scale", 32'(amp_out), 32'hFFF);
    do_update(32'h0, 31'h0, 32'h8000_0000, 16'h0, 12'h000, 1'b0);
    @(negedge clk);
    check("R10 amp zero", 32'(amp_out), 32'h000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_clear();
    test_ext();
    test_azero();
    test_frac(32'h0000_5555, 31'd1, 32'd3, "R5 frac B=3");
    test_frac(32'h0000_3333, 31'd2, 32'd5, "R5 frac B=5");
    test_frac(32'h0000_5555, 31'd1, 32'd0, "R8 B zero");
    test_cont();
    test_hold();
    test_amp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule